// File: doc/BRIEF.md
# Reference Clock Quality Monitor

This block watches one incoming reference clock and samples it with a faster system clock. It uses only rising edges. The time between consecutive rising edges, counted in system clock cycles, tells the block which of five nominal rates the reference carries: 8 kHz, 1.544 MHz, 2.048 MHz, 8.192 MHz or 16.384 MHz. The block reports the detected rate as a three-bit code.

Once a rate is known, two checks run on the reference.

- A coarse check counts rising edges over a fixed window of system cycles and compares the count with the number the rate predicts. It catches large frequency jumps quickly.
- A single-cycle check compares every measured period with the nominal one. It also declares loss of clock when edges stop arriving.

Both checks use hysteresis, so their flags do not chatter near a limit. Their OR forms the disrupted output, which a downstream loop uses to enter holdover. The fail output adds two more causes to the disrupted flag: an externally supplied precise-frequency failure, and the absence of a detected rate.

Top module: `refclk_monitor`

## Requirements
- R1: Only rising edges count. The rate is taken from the rising-to-rising period, so the duty cycle of the reference does not change the detected rate or the flags.
- R2: `rate_code` uses these codes: 0 = 8 kHz (period `P8K`), 1 = 1.544 MHz (`P1M5`), 2 = 2.048 MHz (`P2M`), 3 = 8.192 MHz (`P8M`), 4 = 16.384 MHz (`P16M`) and 7 = no rate.
  - A period matches a rate when it lies within nominal ± (nominal/8 + 1) cycles. The rates are tried fastest first.
  - A new code is adopted after two consecutive periods match the same rate. Periods that match no rate leave the code unchanged.
- R3: The coarse check is active only when the expected window count WIN/nominal is at least `CMIN`. Otherwise it stays clear.
  - The window lasts `WIN` system cycles. At the end of each window, a rising-edge count that differs from WIN/nominal by more than `CBAND` sets the coarse flag.
- R4: The coarse flag clears at a window end only when the deviation is at most `CBAND - CHYS`. A deviation between the two limits keeps the flag in its previous state.
- R5: A measured period outside nominal ± nominal/4 sets the single-cycle flag.
- R6: When no rising edge arrives for more than twice the nominal period, the single-cycle flag is set (loss of clock). The rate code is kept.
- R7: The single-cycle flag clears only after `SCM_CLR` consecutive periods within limits.
- R8: `ref_disrupted` is the OR of the coarse and single-cycle flags. `pfm_fail` has no effect on it.
- R9: `ref_fail` is high when `ref_disrupted` is high, when `pfm_fail` is high, or when no rate is detected.
- R10: After reset, `rate_code` is 7, `ref_disrupted` is 0 and `ref_fail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| pfm_fail | input | 1 | Result from an external precise frequency monitor, high = out of range |
| rate_code | output | 3 | Detected rate code (see R2) |
| ref_fail | output | 1 | Combined failure flag |
| ref_disrupted | output | 1 | Coarse or single-cycle failure, drives holdover |

## Verification
A rising reference edge is seen two cycles after the bench drives it, through the synchroniser and the edge register. A period's results then appear one cycle later:
- the rate code after the second matching period;
- the single-cycle flag at the edge that closes a bad period;
- loss of clock at 2×nominal + 4 cycles after the last driven rise.

The bench checks the loss latency inside a narrow window around that figure. The coarse flag changes only at window ends, so coarse and rate checks are sampled after two to three windows plus several periods of settling. The hysteresis check for the single-cycle flag is sampled between the first and second good edge after the hit.

// File: rtl/refclk_monitor.sv
module refclk_monitor #(
  parameter int P8K     = 8192,
  parameter int P1M5    = 42,
  parameter int P2M     = 32,
  parameter int P8M     = 8,
  parameter int P16M    = 4,
  parameter int WIN     = 2048,
  parameter int CBAND   = 2,
  parameter int CHYS    = 1,
  parameter int CMIN    = 4,
  parameter int SCM_CLR = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       pfm_fail,
  output logic [2:0] rate_code,
  output logic       ref_fail,
  output logic       ref_disrupted
);

  localparam int CMAX = 2 * P8K + 1;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int WW   = $clog2(WIN);
  localparam int EW   = $clog2(WIN + 1);
  localparam int GW   = $clog2(SCM_CLR + 1);
  localparam logic [2:0] NONE = 3'd7;

  function automatic int per_of(input logic [2:0] c);
    case (c)
      3'd0:    return P8K;
      3'd1:    return P1M5;
      3'd2:    return P2M;
      3'd3:    return P8M;
      3'd4:    return P16M;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] cls_of(input int m);
    for (int k = 4; k >= 0; k--) begin
      int p;
      p = per_of(3'(k));
      if (m >= p - (p >> 3) - 1 && m <= p + (p >> 3) + 1) return 3'(k);
    end
    return NONE;
  endfunction

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic [2:0]    prev_q, rate_q;
  logic          scm_q, cfm_q;
  logic [GW-1:0] good_q;
  logic [WW-1:0] wcnt_q;
  logic [EW-1:0] ecnt_q;

  logic       rise, known, lost, bad, rate_chg, wend;
  logic [2:0] cls;
  int         meas, per, expc, etot, dev;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign meas     = int'(cnt_q);
  assign cls      = cls_of(meas);
  assign per      = per_of(rate_q);
  assign known    = rate_q != NONE;
  assign lost     = known && meas > 2 * per;
  assign bad      = known && (meas > per + (per >> 2) || meas < per - (per >> 2));
  assign rate_chg = rise && seen_q && cls != NONE && cls == prev_q && cls != rate_q;
  assign wend     = wcnt_q == WW'(WIN - 1);
  assign expc     = known ? WIN / per : 0;
  assign etot     = int'(ecnt_q) + (rise ? 1 : 0);
  assign dev      = etot > expc ? etot - expc : expc - etot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      prev_q <= NONE;
      rate_q <= NONE;
    end else begin
      sync_q <= {sync_q[1:0], ref_in};
      if (rise) begin
        cnt_q  <= CW'(1);
        seen_q <= 1'b1;
        if (seen_q) prev_q <= cls;
        if (rate_chg) rate_q <= cls;
      end else if (meas < CMAX) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scm_q  <= 1'b0;
      good_q <= '0;
    end else if (!known) begin
      scm_q  <= 1'b0;
      good_q <= '0;
    end else if (lost) begin
      scm_q  <= 1'b1;
      good_q <= '0;
    end else if (rise && seen_q) begin
      if (bad) begin
        scm_q  <= 1'b1;
        good_q <= '0;
      end else if (scm_q) begin
        if (int'(good_q) + 1 >= SCM_CLR) begin
          scm_q  <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + GW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfm_q  <= 1'b0;
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (!known || rate_chg) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      if (!known) cfm_q <= 1'b0;
    end else if (wend) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      if (expc < CMIN)                cfm_q <= 1'b0;
      else if (dev > CBAND)           cfm_q <= 1'b1;
      else if (dev <= CBAND - CHYS)   cfm_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_q + WW'(1);
      ecnt_q <= ecnt_q + EW'(rise);
    end
  end

  assign rate_code     = rate_q;
  assign ref_disrupted = scm_q | cfm_q;
  assign ref_fail      = ref_disrupted | pfm_fail | ~known;

  p_rate_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(rate_q));
  p_bad_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen_q && bad) |=> scm_q);
  p_loss_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !rise) |=> scm_q);
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas <= CMAX);
  p_scm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_q) |-> $past(rise));
  p_cfm_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (known && !wend && !rate_chg) |=> $stable(cfm_q));
  p_dis_in_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_disrupted |-> ref_fail);

endmodule

// File: tb/test_refclk_monitor.sv
module test_refclk_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int P8K = 256, WIN = 512, CBAND = 3, CHYS = 2;
  localparam int NOM [5] = '{256, 42, 32, 8, 4};

  logic       clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, pfm_fail = 1'b0;
  logic [2:0] rate_code;
  logic       ref_fail, ref_disrupted;

  int n_chk = 0, n_fail = 0, cyc = 0, last_rise = 0;
  int per_v = 20, high_v = 5, hit_p = 0, seq_i = 0, gen_p = 0;
  bit run_en = 1'b0, pat = 1'b0;

  refclk_monitor #(.P8K(P8K), .WIN(WIN), .CBAND(CBAND), .CHYS(CHYS)) i_refclk_monitor (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pfm_fail(pfm_fail),
    .rate_code(rate_code), .ref_fail(ref_fail), .ref_disrupted(ref_disrupted));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always begin
    if (!run_en) begin
      ref_in = 1'b0;
      @(negedge clk);
    end else begin
      if (hit_p != 0) begin
        gen_p = hit_p;
        hit_p = 0;
      end else begin
        gen_p = (pat && (seq_i % 3 == 2)) ? per_v + 1 : per_v;
      end
      seq_i++;
      ref_in = 1'b1;
      last_rise = cyc;
      repeat (high_v) @(negedge clk);
      ref_in = 1'b0;
      repeat (gen_p - high_v) @(negedge clk);
    end
  end

  function automatic int exp_code(input int p);
    for (int k = 4; k >= 0; k--)
      if (p >= NOM[k] - NOM[k] / 8 - 1 && p <= NOM[k] + NOM[k] / 8 + 1) return k;
    return 7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ref(input int p, input int h);
    per_v = p;
    high_v = h;
    run_en = 1'b1;
  endtask

  task automatic wait_dis(input bit level, input int limit, output int waited);
    waited = 0;
    while (ref_disrupted !== level && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    int w;
    void'($urandom(32'd1377));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R10 rate after reset", rate_code, 7);
    chk("R10 disrupted after reset", ref_disrupted, 0);
    chk("R10 fail after reset", ref_fail, 1);

    set_ref(20, 7);
    wait_n(20 * 12);
    chk("R2 out-of-band period keeps code", rate_code, 7);
    chk("R9 fail with no rate", ref_fail, 1);

    set_ref(42, 1);
    wait_n(42 * 8 + 3 * WIN);
    chk("R1 narrow high time code", rate_code, exp_code(42));
    chk("R1 narrow high time disrupted", ref_disrupted, 0);
    high_v = 41;
    wait_n(42 * 8 + 3 * WIN);
    chk("R1 wide high time code", rate_code, 1);
    chk("R1 wide high time disrupted", ref_disrupted, 0);
    pfm_fail = 1'b1;
    wait_n(3);
    chk("R9 pfm_fail raises fail", ref_fail, 1);
    chk("R8 pfm_fail leaves disrupted", ref_disrupted, 0);
    pfm_fail = 1'b0;
    wait_n(3);
    chk("R9 fail clears", ref_fail, 0);

    hit_p = 60;
    wait_dis(1'b1, 300, w);
    chk("R5 phase hit sets disrupted", ref_disrupted, 1);
    wait_n(50);
    chk("R7 held after one good period", ref_disrupted, 1);
    chk("R5 hit keeps rate", rate_code, 1);
    wait_n(50);
    chk("R7 cleared after two good periods", ref_disrupted, 0);

    set_ref(8, 3);
    wait_n(8 * 10 + 3 * WIN);
    chk("R2 rate 8.192", rate_code, 3);
    chk("R3 steady count clear", ref_disrupted, 0);
    pat = 1'b1;
    wait_n(3 * WIN);
    chk("R4 mid-band deviation keeps clear", ref_disrupted, 0);
    pat = 1'b0;
    per_v = 10;
    wait_n(3 * WIN);
    chk("R3 large count deviation sets", ref_disrupted, 1);
    chk("R3 deviation keeps rate", rate_code, 3);
    pat = 1'b1;
    per_v = 8;
    wait_n(3 * WIN);
    chk("R4 mid-band deviation keeps set", ref_disrupted, 1);
    pat = 1'b0;
    wait_n(3 * WIN);
    chk("R4 small deviation clears", ref_disrupted, 0);

    set_ref(32, 16);
    wait_n(32 * 10 + 3 * WIN);
    chk("R2 rate 2.048", rate_code, 2);
    chk("R6 no disruption before stop", ref_disrupted, 0);
    run_en = 1'b0;
    wait_dis(1'b1, 400, w);
    chk("R6 loss of clock flagged", ref_disrupted, 1);
    w = cyc - last_rise;
    chk("R6 loss latency in window", int'(w >= 2 * 32 + 1 && w <= 2 * 32 + 6), 1);
    chk("R6 rate kept on loss", rate_code, 2);
    chk("R9 fail on loss", ref_fail, 1);
    run_en = 1'b1;
    wait_n(32 * 10 + 3 * WIN);
    chk("R7 recovery after loss", ref_disrupted, 0);

    set_ref(280, 100);
    wait_n(280 * 10 + 3 * WIN);
    chk("R2 rate 8 kHz off-nominal", rate_code, 0);
    chk("R3 coarse inactive at slow rate", ref_disrupted, 0);

    for (int i = 0; i < 8; i++) begin
      int k;
      bit pf;
      k = $urandom % 5;
      pf = 1'($urandom % 2);
      set_ref(NOM[k], 1 + $urandom % (NOM[k] - 1));
      pfm_fail = pf;
      wait_n(NOM[k] * 8 + 3 * WIN);
      chk("R2 random rate code", rate_code, exp_code(NOM[k]));
      chk("R8 random disrupted", ref_disrupted, 0);
      chk("R9 random fail", ref_fail, int'(pf));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule